// File: doc/BRIEF.md
# HDLC Receive Framer with Block-Handshake FIFO

This block receives a serial HDLC bitstream, one bit per strobe, and finds frame boundaries on flag octets. Inside a frame it removes the zero bits the sender inserted and checks the frame check sequence. Only the octets between the opening flag and the two check octets are stored. These are normally the address, control and information fields.

Storage is a 128-byte buffer split into two 64-byte halves. A host takes the data one half at a time. It sees a "block ready" status when 64 octets of a frame that is still running are waiting. It sees an "end" status with a 6-bit residual count when the last part of a frame has arrived. The host reads the octets in order and then acknowledges, which releases that half. While the host drains one half, reception continues into the other. If the host is so late that both halves are held, further octets are dropped and an overflow is signalled.

Top module: `hdlc_rx_fifo_ctrl`

## Requirements
- R1: A flag is the octet 0x7E (bits 0,1,1,1,1,1,1,0 in line order). The receiver hunts after reset. Octets between two flags, except the last two, are payload and are stored in line order. Each octet is assembled least-significant bit first. A frame of fewer than three octets produces no status.
- R2: Inside a frame, a zero that follows five consecutive ones is deleted before the octets are assembled.
- R3: The check is CRC-16 with polynomial x^16+x^12+x^5+1 in reflected form (0x8408), preset 0xFFFF. It runs over payload and check octets, least-significant bit first, and the check octets are sent low octet first. If the remainder at the closing flag is not 0xF0B8, or the frame is not a whole number of octets, `crc_bad` reads 1 while the end status is shown. Otherwise it reads 0.
- R4: `msg_ready` rises once a half holds 64 payload octets of a frame and at least one more payload octet has followed. Each `host_rd` pulse steps `rd_data` to the next octet of the shown half.
- R5: At the closing flag, `msg_end` is raised for the half that holds the frame's last octets. `seg_cnt` then gives their number, from 1 to 63, or 0 when the half holds exactly 64. A frame whose final part is exactly 64 octets raises no `msg_ready` for that part.
- R6: A shown status and its `seg_cnt` stay unchanged until `host_ack`. `msg_ready` and `msg_end` are never high together. After an acknowledge, the read position restarts at 0 and the other half's status, if any, is shown.
- R7: A payload octet that must go into a half still held by the host is dropped. Each drop gives a one-cycle `ovf_irq` pulse and sets `ovf_flag`. `ovf_flag` stays set until the next acknowledge takes effect. With both halves held, 128 octets are accepted before the first drop.
- R8: Seven consecutive ones abort a frame. Its octets that have not yet been announced are discarded, no status is raised, and the receiver hunts for the next flag.
- R9: The payload of each new frame starts at position 0 of the half after the one its predecessor ended in.
- R10: After reset, `msg_ready`, `msg_end`, `ovf_irq` and `ovf_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_vld | input | 1 | Strobe: `bit_in` carries a line bit this cycle |
| bit_in | input | 1 | Serial line bit |
| host_rd | input | 1 | Step to the next octet of the shown half |
| host_ack | input | 1 | Release the shown half |
| rd_data | output | 8 | Octet at the current read position of the shown half |
| msg_ready | output | 1 | Shown half is a full 64-octet block of a running frame |
| msg_end | output | 1 | Shown half holds the final part of a frame |
| seg_cnt | output | 6 | Octet count of the final part (0 means 64) |
| crc_bad | output | 1 | Check failed for the frame whose end is shown |
| ovf_irq | output | 1 | One-cycle pulse for each dropped octet |
| ovf_flag | output | 1 | Sticky overflow status, cleared by acknowledge |

## Verification
A wrong one-count or flag history in the framer shows up first in the octets the host reads. It appears at the very next block shown, either as shifted or flipped data or as a check failure on a good frame. A half ownership bit stuck at the wrong value shows up as a lost or repeated block, or as early drops counted on `ovf_irq`. Both are visible within one frame. The frames chosen cross the 64-octet boundary on both sides and land exactly on it. They contain runs of ones that force bit deletion, and they include an abort and a host that stalls past both halves. Each of these internal faults therefore reaches the ports within a few hundred bit strobes.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

  localparam logic [15:0] CRC_POLY_REFL = 16'h8408;
  localparam logic [15:0] CRC_PRESET    = 16'hFFFF;
  localparam logic [15:0] CRC_RESIDUE   = 16'hF0B8;
  localparam int          FLAG_LEAD     = 7;  // flag bits seen before it is recognised

  typedef enum logic [1:0] {
    BIT_DATA,
    BIT_STUFF,
    BIT_FLAG,
    BIT_ABORT
  } bit_cls_e;

  // Meaning of the incoming bit given the run of ones before it.
  function automatic bit_cls_e classify(input logic [2:0] ones, input logic b);
    if (!b && ones == 3'd5) return BIT_STUFF;
    if (!b && ones == 3'd6) return BIT_FLAG;
    if (b && ones == 3'd6)  return BIT_ABORT;
    return BIT_DATA;
  endfunction

  // One step of the reflected CRC-16 register.
  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    logic fb;
    fb = c[0] ^ b;
    return (c >> 1) ^ (fb ? CRC_POLY_REFL : 16'h0000);
  endfunction

endpackage

// File: rtl/hdlc_crc16.sv
module hdlc_crc16
  import hdlc_rx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic        bit_in,
  output logic [15:0] crc_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc_o <= CRC_PRESET;
    else if (clr) crc_o <= CRC_PRESET;
    else if (en)  crc_o <= crc_step(crc_o, bit_in);
  end

endmodule

// File: rtl/hdlc_deframer.sv
module hdlc_deframer
  import hdlc_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_vld,
  input  logic       bit_in,
  output logic       byte_vld,
  output logic [7:0] byte_q,
  output logic       frm_end,
  output logic       frm_good,
  output logic       frm_abort,
  output logic       frm_sync
);

  localparam int QN_W = $clog2(FLAG_LEAD + 1);
  localparam logic [QN_W-1:0] Q_FULL = QN_W'(FLAG_LEAD);

  logic [2:0]           ones_q;
  logic                 in_frame_q;
  logic [FLAG_LEAD-1:0] dq_q;
  logic [QN_W-1:0]      qn_q;
  logic [2:0]           bitcnt_q;
  logic [7:0]           sh_q;
  logic [15:0]          crc_w;
  bit_cls_e             cls;
  logic                 push, commit, cbit, flag_hit;

  assign cls      = classify(ones_q, bit_in);
  assign push     = bit_vld && (cls == BIT_DATA) && in_frame_q;
  assign commit   = push && (qn_q == Q_FULL);
  assign cbit     = dq_q[0];
  assign flag_hit = bit_vld && (cls == BIT_FLAG);

  hdlc_crc16 u_crc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (flag_hit),
    .en     (commit),
    .bit_in (cbit),
    .crc_o  (crc_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q     <= '0;
      in_frame_q <= 1'b0;
      dq_q       <= '0;
      qn_q       <= '0;
      bitcnt_q   <= '0;
      sh_q       <= '0;
      byte_vld   <= 1'b0;
      byte_q     <= '0;
      frm_end    <= 1'b0;
      frm_good   <= 1'b0;
      frm_abort  <= 1'b0;
      frm_sync   <= 1'b0;
    end else begin
      byte_vld  <= 1'b0;
      frm_end   <= 1'b0;
      frm_abort <= 1'b0;
      frm_sync  <= 1'b0;
      if (bit_vld) begin
        if (bit_in) ones_q <= (ones_q == 3'd7) ? 3'd7 : ones_q + 3'd1;
        else        ones_q <= '0;
        case (cls)
          BIT_FLAG: begin
            frm_end    <= in_frame_q;
            frm_good   <= (crc_w == CRC_RESIDUE) && (bitcnt_q == 3'd0);
            frm_sync   <= 1'b1;
            in_frame_q <= 1'b1;
            qn_q       <= '0;
            bitcnt_q   <= '0;
          end
          BIT_ABORT: begin
            frm_abort  <= in_frame_q;
            frm_sync   <= 1'b1;
            in_frame_q <= 1'b0;
            qn_q       <= '0;
            bitcnt_q   <= '0;
          end
          BIT_STUFF: ;
          default: begin
            if (in_frame_q) begin
              dq_q <= {bit_in, dq_q[FLAG_LEAD-1:1]};
              if (qn_q != Q_FULL) qn_q <= qn_q + 1'b1;
              if (commit) begin
                sh_q     <= {cbit, sh_q[7:1]};
                bitcnt_q <= bitcnt_q + 3'd1;
                if (bitcnt_q == 3'd7) begin
                  byte_vld <= 1'b1;
                  byte_q   <= {cbit, sh_q[7:1]};
                end
              end
            end
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/hdlc_holdback.sv
module hdlc_holdback #(
  parameter  int DEPTH = 2,
  parameter  int W     = 8,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         in_vld,
  input  logic [W-1:0] in_byte,
  output logic         out_vld,
  output logic [W-1:0] out_byte
);

  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [W-1:0]  hold_q [DEPTH];
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      out_vld  <= 1'b0;
      out_byte <= '0;
      for (int i = 0; i < DEPTH; i++) hold_q[i] <= '0;
    end else begin
      out_vld <= 1'b0;
      if (clr) begin
        cnt_q <= '0;
      end else if (in_vld) begin
        if (cnt_q == FULL) begin
          out_vld  <= 1'b1;
          out_byte <= hold_q[DEPTH-1];
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        hold_q[0] <= in_byte;
        for (int i = 1; i < DEPTH; i++) hold_q[i] <= hold_q[i-1];
      end
    end
  end

endmodule

// File: rtl/hdlc_blk_buf.sv
module hdlc_blk_buf #(
  parameter  int BLK   = 64,
  parameter  int W     = 8,
  localparam int IDX_W = $clog2(BLK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pay_vld,
  input  logic [W-1:0]     pay_byte,
  input  logic             frm_end,
  input  logic             frm_good,
  input  logic             frm_abort,
  input  logic             host_rd,
  input  logic             host_ack,
  output logic [W-1:0]     rd_data,
  output logic             msg_ready,
  output logic             msg_end,
  output logic [IDX_W-1:0] seg_cnt,
  output logic             crc_bad,
  output logic             ovf_irq,
  output logic             ovf_flag,
  output logic             ev_announce,
  output logic             ev_half,
  output logic             ev_drop,
  output logic [1:0]       half_busy,
  output logic             wr_half
);

  localparam logic [IDX_W:0] FULL_MARK = (IDX_W + 1)'(BLK);

  // Residual count code: a full half reads as zero.
  function automatic logic [IDX_W-1:0] len_code(input logic [IDX_W:0] n);
    return n[IDX_W-1:0];
  endfunction

  function automatic logic [IDX_W:0] addr(input logic h, input logic [IDX_W-1:0] i);
    return {h, i};
  endfunction

  logic [W-1:0]     mem_q [2*BLK];
  logic             wr_half_q, hd_q;
  logic [IDX_W:0]   wr_idx_q;
  logic [IDX_W-1:0] rd_idx_q;
  logic [1:0]       busy_q, end_q, bad_q;
  logic [IDX_W-1:0] cnt_q [2];
  logic             ovf_q, drop_q;

  logic seg_full, tgt_half, wr_ok, ann_ready, ann_end, ack_fire;

  assign seg_full    = (wr_idx_q == FULL_MARK);
  assign tgt_half    = seg_full ? ~wr_half_q : wr_half_q;
  assign wr_ok       = pay_vld && !busy_q[tgt_half];
  assign ev_drop     = pay_vld && busy_q[tgt_half];
  assign ann_ready   = pay_vld && seg_full;
  assign ann_end     = frm_end && (wr_idx_q != '0);
  assign ev_announce = ann_ready || ann_end;
  assign ev_half     = wr_half_q;
  assign ack_fire    = host_ack && busy_q[hd_q];

  // Write side: fill position and half selection.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_half_q <= 1'b0;
      wr_idx_q  <= '0;
    end else if (frm_abort) begin
      wr_idx_q <= '0;
    end else if (ann_end) begin
      wr_half_q <= ~wr_half_q;
      wr_idx_q  <= '0;
    end else if (pay_vld) begin
      if (seg_full) begin
        wr_half_q <= ~wr_half_q;
        wr_idx_q  <= wr_ok ? (IDX_W + 1)'(1) : '0;
      end else if (wr_ok) begin
        wr_idx_q <= wr_idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem_q[addr(tgt_half, wr_idx_q[IDX_W-1:0])] <= pay_byte;
  end

  // Per-half ownership and status.
  for (genvar h = 0; h < 2; h++) begin : g_half
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        busy_q[h] <= 1'b0;
        end_q[h]  <= 1'b0;
        bad_q[h]  <= 1'b0;
        cnt_q[h]  <= '0;
      end else if (ev_announce && (ev_half == 1'(h))) begin
        busy_q[h] <= 1'b1;
        end_q[h]  <= ann_end;
        bad_q[h]  <= ann_end && !frm_good;
        cnt_q[h]  <= ann_end ? len_code(wr_idx_q) : '0;
      end else if (ack_fire && (hd_q == 1'(h))) begin
        busy_q[h] <= 1'b0;
      end
    end
  end

  // Host side: shown half and read position.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hd_q     <= 1'b0;
      rd_idx_q <= '0;
    end else if (ack_fire) begin
      hd_q     <= ~hd_q;
      rd_idx_q <= '0;
    end else if (host_rd && busy_q[hd_q]) begin
      rd_idx_q <= rd_idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q  <= 1'b0;
      drop_q <= 1'b0;
    end else begin
      drop_q <= ev_drop;
      if (ev_drop)       ovf_q <= 1'b1;
      else if (ack_fire) ovf_q <= 1'b0;
    end
  end

  assign rd_data   = mem_q[addr(hd_q, rd_idx_q)];
  assign msg_ready = busy_q[hd_q] && !end_q[hd_q];
  assign msg_end   = busy_q[hd_q] && end_q[hd_q];
  assign seg_cnt   = cnt_q[hd_q];
  assign crc_bad   = msg_end && bad_q[hd_q];
  assign ovf_irq   = drop_q;
  assign ovf_flag  = ovf_q;
  assign half_busy = busy_q;
  assign wr_half   = wr_half_q;

endmodule

// File: rtl/hdlc_rx_fifo_ctrl.sv
module hdlc_rx_fifo_ctrl #(
  parameter  int BLK_BYTES = 64,
  localparam int CNT_W     = $clog2(BLK_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_vld,
  input  logic             bit_in,
  input  logic             host_rd,
  input  logic             host_ack,
  output logic [7:0]       rd_data,
  output logic             msg_ready,
  output logic             msg_end,
  output logic [CNT_W-1:0] seg_cnt,
  output logic             crc_bad,
  output logic             ovf_irq,
  output logic             ovf_flag
);

  localparam int CHK_OCTETS = 2;

  // Internal events, named for the checker.
  logic       byte_vld, frm_end, frm_good, frm_abort, frm_sync;
  logic [7:0] byte_q;
  logic       pay_vld;
  logic [7:0] pay_byte;
  logic       ev_announce, ev_half, ev_drop, wr_half;
  logic [1:0] half_busy;

  hdlc_deframer u_deframer (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_vld   (bit_vld),
    .bit_in    (bit_in),
    .byte_vld  (byte_vld),
    .byte_q    (byte_q),
    .frm_end   (frm_end),
    .frm_good  (frm_good),
    .frm_abort (frm_abort),
    .frm_sync  (frm_sync)
  );

  hdlc_holdback #(.DEPTH(CHK_OCTETS), .W(8)) u_holdback (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (frm_sync),
    .in_vld   (byte_vld),
    .in_byte  (byte_q),
    .out_vld  (pay_vld),
    .out_byte (pay_byte)
  );

  hdlc_blk_buf #(.BLK(BLK_BYTES), .W(8)) u_buf (
    .clk         (clk),
    .rst_n       (rst_n),
    .pay_vld     (pay_vld),
    .pay_byte    (pay_byte),
    .frm_end     (frm_end),
    .frm_good    (frm_good),
    .frm_abort   (frm_abort),
    .host_rd     (host_rd),
    .host_ack    (host_ack),
    .rd_data     (rd_data),
    .msg_ready   (msg_ready),
    .msg_end     (msg_end),
    .seg_cnt     (seg_cnt),
    .crc_bad     (crc_bad),
    .ovf_irq     (ovf_irq),
    .ovf_flag    (ovf_flag),
    .ev_announce (ev_announce),
    .ev_half     (ev_half),
    .ev_drop     (ev_drop),
    .half_busy   (half_busy),
    .wr_half     (wr_half)
  );

endmodule

// File: rtl/hdlc_rx_fifo_ctrl_chk.sv
module hdlc_rx_fifo_ctrl_chk #(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             msg_ready,
  input logic             msg_end,
  input logic [CNT_W-1:0] seg_cnt,
  input logic             host_ack,
  input logic             ovf_irq,
  input logic             ovf_flag,
  input logic             ev_announce,
  input logic             ev_half,
  input logic             ev_drop,
  input logic [1:0]       half_busy,
  input logic             byte_vld,
  input logic             frm_end,
  input logic             frm_abort
);

  p_excl_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(msg_ready && msg_end));

  p_end_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_end && !host_ack) |=> (msg_end && $stable(seg_cnt)));

  p_ready_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_ready && !host_ack) |=> msg_ready);

  p_announce_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_announce |-> !half_busy[ev_half]);

  p_drop_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop |=> (ovf_irq && ovf_flag));

  p_drop_needs_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop |-> (half_busy != 2'b00));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !host_ack) |=> ovf_flag);

  p_frame_events_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({byte_vld, frm_end, frm_abort}));

endmodule

bind hdlc_rx_fifo_ctrl hdlc_rx_fifo_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .msg_ready   (msg_ready),
  .msg_end     (msg_end),
  .seg_cnt     (seg_cnt),
  .host_ack    (host_ack),
  .ovf_irq     (ovf_irq),
  .ovf_flag    (ovf_flag),
  .ev_announce (ev_announce),
  .ev_half     (ev_half),
  .ev_drop     (ev_drop),
  .half_busy   (half_busy),
  .byte_vld    (byte_vld),
  .frm_end     (frm_end),
  .frm_abort   (frm_abort)
);

// File: tb/hdlc_rx_fifo_ctrl_bench.sv
module hdlc_rx_fifo_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_vld = 1'b0, bit_in = 1'b1;
  logic       host_rd = 1'b0, host_ack = 1'b0;
  logic [7:0] rd_data;
  logic       msg_ready, msg_end, crc_bad, ovf_irq, ovf_flag;
  logic [5:0] seg_cnt;

  always #10 clk = ~clk;

  hdlc_rx_fifo_ctrl u_hdlc_rx_fifo_ctrl (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
    .host_rd(host_rd), .host_ack(host_ack), .rd_data(rd_data),
    .msg_ready(msg_ready), .msg_end(msg_end), .seg_cnt(seg_cnt),
    .crc_bad(crc_bad), .ovf_irq(ovf_irq), .ovf_flag(ovf_flag)
  );

  int n_chk = 0, n_fail = 0;
  int ovf_seen = 0;
  int tx_ones = 0;
  bit hold = 1'b0, serving = 1'b0, done = 1'b0;

  // Scoreboard: one entry per expected block, octets in a flat queue.
  bit         exp_end[$];
  logic [5:0] exp_cnt[$];
  bit         exp_bad[$];
  string      exp_req[$];
  logic [7:0] exp_data[$];
  logic [7:0] pl[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [7:0] q[$]);
    logic [15:0] c = 16'hFFFF;
    foreach (q[i]) for (int k = 0; k < 8; k++) begin
      if (c[0] ^ q[i][k]) c = (c >> 1) ^ 16'h8408;
      else                c = c >> 1;
    end
    return c;
  endfunction

  function automatic void make_payload(input int n, input int seed);
    pl.delete();
    for (int k = 0; k < n; k++) begin
      if (k % 7 == 3)       pl.push_back(8'hFF);
      else if (k % 11 == 5) pl.push_back(8'h7E);
      else                  pl.push_back(8'((k * 37 + seed) & 255));
    end
  endfunction

  task automatic raw_bit(input logic b);
    @(negedge clk); bit_vld = 1'b1; bit_in = b;
    @(negedge clk); bit_vld = 1'b0;
  endtask

  task automatic send_flag();
    logic [7:0] f = 8'h7E;
    for (int k = 0; k < 8; k++) raw_bit(f[k]);
    tx_ones = 0;
  endtask

  task automatic stuffed_byte(input logic [7:0] v);
    for (int k = 0; k < 8; k++) begin
      raw_bit(v[k]);
      if (v[k]) begin
        tx_ones++;
        if (tx_ones == 5) begin raw_bit(1'b0); tx_ones = 0; end
      end else tx_ones = 0;
    end
  endtask

  task automatic push_item(input bit is_end, input logic [5:0] cnt,
                           input bit bad, input string req,
                           input int from, input int num);
    exp_end.push_back(is_end); exp_cnt.push_back(cnt);
    exp_bad.push_back(bad);    exp_req.push_back(req);
    for (int k = from; k < from + num; k++) exp_data.push_back(pl[k]);
  endtask

  task automatic send_frame(input bit corrupt, input bit expect_it, input string req);
    logic [15:0] c = ~ref_crc(pl);
    int n = pl.size();
    int off = 0;
    if (corrupt) c[0] = ~c[0];
    if (expect_it) begin
      while (n - off > 64) begin push_item(1'b0, 6'd0, 1'b0, req, off, 64); off += 64; end
      push_item(1'b1, 6'((n - off) % 64), corrupt, req, off, n - off);
    end
    send_flag();
    foreach (pl[i]) stuffed_byte(pl[i]);
    stuffed_byte(c[7:0]);
    stuffed_byte(c[15:8]);
    send_flag();
  endtask

  task automatic drain();
    wait (exp_end.size() == 0 && !serving);
    repeat (20) @(negedge clk);
  endtask

  // Monitor: serves each shown block and compares it with the scoreboard.
  task automatic serve();
    bit         e, is_e;
    logic [5:0] cnt;
    bit         bad;
    string      req;
    int         n, miss = 0;
    logic [7:0] got, want;
    serving = 1'b1;
    is_e = msg_end;
    if (exp_end.size() == 0) begin
      check(1'b0, "R1", "unexpected block shown", int'(is_e), -1);
      n = 1;
    end else begin
      e = exp_end.pop_front(); cnt = exp_cnt.pop_front();
      bad = exp_bad.pop_front(); req = exp_req.pop_front();
      check(is_e == e, e ? "R5" : "R4", {req, " block kind end"}, int'(is_e), int'(e));
      if (e) begin
        check(seg_cnt == cnt, "R5", {req, " seg_cnt"}, int'(seg_cnt), int'(cnt));
        check(crc_bad == bad, "R3", {req, " crc_bad"}, int'(crc_bad), int'(bad));
      end
      n = e ? ((cnt == 0) ? 64 : int'(cnt)) : 64;
      for (int k = 0; k < n; k++) begin
        got = rd_data; want = exp_data.pop_front();
        if (got !== want && miss == 0)
          check(1'b0, "R2", {req, " octet mismatch"}, int'(got), int'(want));
        if (got !== want) miss++;
        host_rd = 1'b1; @(negedge clk); host_rd = 1'b0;
      end
      if (miss == 0) check(1'b1, "R2", "octets", 0, 0);
    end
    host_ack = 1'b1; @(negedge clk); host_ack = 1'b0;
    serving = 1'b0;
  endtask

  always @(negedge clk) if (rst_n && ovf_irq) ovf_seen++;

  initial begin
    wait (rst_n);
    forever begin
      @(negedge clk);
      if (!hold && (msg_ready || msg_end)) serve();
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    check(!msg_ready && !msg_end, "R10", "status after reset", int'({msg_ready, msg_end}), 0);
    check(!ovf_flag && !ovf_irq, "R10", "overflow after reset", int'({ovf_flag, ovf_irq}), 0);
    rst_n = 1'b1;
    for (int k = 0; k < 16; k++) raw_bit(1'b1);

    make_payload(10, 3);  send_frame(1'b0, 1'b1, "R1 short good frame");
    make_payload(5, 9);   send_frame(1'b1, 1'b1, "R3 bad check");
    make_payload(64, 21); send_frame(1'b0, 1'b1, "R5 exact block");
    make_payload(100, 4); send_frame(1'b0, 1'b1, "R9 two halves");
    drain();

    // R1: two octets only between flags -> nothing shown.
    send_flag(); stuffed_byte(8'h12); stuffed_byte(8'h34); send_flag();
    // R8: partial frame then abort, then a good frame.
    make_payload(30, 55);
    send_flag(); foreach (pl[i]) stuffed_byte(pl[i]);
    for (int k = 0; k < 10; k++) raw_bit(1'b1);
    make_payload(20, 77); send_frame(1'b0, 1'b1, "R8 after abort");
    drain();

    // R7: host stalls through a 140-octet frame.
    hold = 1'b1;
    ovf_seen = 0;
    make_payload(140, 13);
    push_item(1'b0, 6'd0, 1'b0, "R7 held first", 0, 64);
    push_item(1'b0, 6'd0, 1'b0, "R7 held second", 64, 64);
    send_frame(1'b0, 1'b0, "R7");
    repeat (40) @(negedge clk);
    check(ovf_seen == 12, "R7", "dropped octet pulses", ovf_seen, 12);
    check(ovf_flag == 1'b1, "R7", "ovf_flag while held", int'(ovf_flag), 1);
    check(msg_ready == 1'b1, "R4", "ready shown while held", int'(msg_ready), 1);
    hold = 1'b0;
    drain();
    check(ovf_flag == 1'b0, "R7", "ovf_flag after ack", int'(ovf_flag), 0);

    make_payload(65, 40); send_frame(1'b0, 1'b1, "R4 one past block");
    drain();
    check(exp_end.size() == 0, "R6", "blocks outstanding", exp_end.size(), 0);
    check(!msg_ready && !msg_end, "R6", "idle after last ack",
          int'({msg_ready, msg_end}), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule